// File: doc/BRIEF.md
# Four-Lane 16-bit Integer Vector ALU

This block is a registered integer ALU that takes two 64-bit vector operands. Each operand carries four 16-bit components: X in bits 15:0, Y in bits 31:16, Z in bits 47:32 and W in bits 63:48. An 8-bit opcode selects one of these operations: a lane-wise 16-bit add, a 32-bit add over the fused XY and ZW pairs, signed and unsigned low-half multiplies, signed and unsigned full-width multiplies of the X and Z lanes, and bitwise AND, OR and XOR.

The caller presents the operands, the opcode and an input valid strobe. One clock later the block returns the 64-bit result with an output valid strobe. With the result it also returns a sign bit and a zero bit for each component, which a downstream flag unit can use. If the opcode is not supported, the result is zero and an illegal-operation output is raised for that one cycle.

Top module: `vecIntAlu`

## Requirements
- R1: Opcode 0x21 adds each 16-bit component of A to the matching component of B. Each lane wraps modulo 2^16 and no carry passes between lanes.
- R2: Opcode 0x22 adds {Y,X} of A to {Y,X} of B, and {W,Z} of A to {W,Z} of B, as 32-bit integers modulo 2^32. The carry out of X enters Y, and the carry out of Z enters W. No carry passes from Y into Z.
- R3: Opcode 0x2C multiplies each pair of matching components as signed 16-bit values and keeps the low 16 bits of each product.
- R4: Opcode 0x28 multiplies each pair of matching components as unsigned 16-bit values and keeps the low 16 bits of each product.
- R5: Opcode 0x2E forms the signed 32-bit product A.X*B.X and writes it to result bits 31:0, with the low half in X. It forms the signed 32-bit product A.Z*B.Z and writes it to result bits 63:32.
- R6: Opcode 0x2A does the same as R5, but treats the operands as unsigned.
- R7: Opcodes 0x30, 0x31 and 0x32 give the bitwise AND, OR and XOR of the full 64 bits.
- R8: The output valid is high exactly one cycle after the input valid. The result and status update only on an accepted input and are held otherwise.
- R9: An unsupported opcode, accepted with the input valid, gives a zero result and raises the illegal-operation output together with the output valid for that one cycle.
- R10: For each component i, the sign output bit i equals bit 15 of result component i. The zero output bit i is 1 exactly when result component i is zero. Both are registered together with the result.
- R11: After reset the output valid, the illegal-operation output, the result, the sign outputs and the zero outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opCode | input | 8 | Operation select |
| srcA | input | 64 | Operand A, X in bits 15:0 |
| srcB | input | 64 | Operand B, X in bits 15:0 |
| outValid | output | 1 | Result is valid |
| result | output | 64 | Registered result |
| illegalOp | output | 1 | The accepted opcode was unsupported |
| signOut | output | 4 | Bit 15 of each result component, bit 0 for X |
| zeroOut | output | 4 | Result component equals zero, bit 0 for X |

## Verification
The adds are tried with operands of 0xFFFF plus 1 in single lanes. This shows whether carries stay inside a lane for the 16-bit add, and whether they cross from X into Y but not from Y into Z for the 32-bit add. The multiplies use negative values such as 0xFFFF and 0x8000, whose signed and unsigned products differ, so a swapped signed and unsigned decode shows up. A sweep of pseudo-random operands through every opcode is compared with a bench-side model. Idle cycles check that the result is held, and an unknown opcode checks the zero result and the one-cycle illegal flag.

// File: rtl/vecIntAlu_pkg.sv
package vecIntAlu_pkg;
  localparam int LANE_W  = 16;
  localparam int LANES   = 4;
  localparam int VEC_W   = LANE_W * LANES;
  localparam int OP_W    = 8;

  localparam logic [OP_W-1:0] OP_ADD16  = 8'h21;
  localparam logic [OP_W-1:0] OP_ADD32  = 8'h22;
  localparam logic [OP_W-1:0] OP_MULLOU = 8'h28;
  localparam logic [OP_W-1:0] OP_MULHIU = 8'h2A;
  localparam logic [OP_W-1:0] OP_MULLOS = 8'h2C;
  localparam logic [OP_W-1:0] OP_MULHIS = 8'h2E;
  localparam logic [OP_W-1:0] OP_AND    = 8'h30;
  localparam logic [OP_W-1:0] OP_OR     = 8'h31;
  localparam logic [OP_W-1:0] OP_XOR    = 8'h32;

  typedef enum logic [2:0] {
    SEL_ADD, SEL_MULLO, SEL_MULHI, SEL_AND, SEL_OR, SEL_XOR, SEL_NONE
  } selT;

  typedef struct packed {
    logic load;
    selT  sel;
    logic fuse;
    logic signedMul;
    logic illegal;
  } ctrlT;
endpackage

// File: rtl/vecIntAluCtrl.sv
module vecIntAluCtrl
  import vecIntAlu_pkg::*;
(
  input  logic            inValid,
  input  logic [OP_W-1:0] opCode,
  output ctrlT            ctrl
);
  always_comb begin
    ctrl = '{load: inValid, sel: SEL_NONE, fuse: 1'b0, signedMul: 1'b0, illegal: 1'b0};
    unique case (opCode)
      OP_ADD16:  ctrl.sel = SEL_ADD;
      OP_ADD32:  begin ctrl.sel = SEL_ADD; ctrl.fuse = 1'b1; end
      OP_MULLOU: ctrl.sel = SEL_MULLO;
      OP_MULLOS: begin ctrl.sel = SEL_MULLO; ctrl.signedMul = 1'b1; end
      OP_MULHIU: ctrl.sel = SEL_MULHI;
      OP_MULHIS: begin ctrl.sel = SEL_MULHI; ctrl.signedMul = 1'b1; end
      OP_AND:    ctrl.sel = SEL_AND;
      OP_OR:     ctrl.sel = SEL_OR;
      OP_XOR:    ctrl.sel = SEL_XOR;
      default:   ctrl.illegal = inValid;
    endcase
  end

  always_comb begin
    if (inValid && ctrl.illegal)
      assert (ctrl.sel == SEL_NONE) else $error("illegal decode selected a unit"); // R9
  end
endmodule

// File: rtl/vecIntAluPath.sv
module vecIntAluPath
  import vecIntAlu_pkg::*;
#(
  parameter int LaneW = LANE_W,
  parameter int Lanes = LANES
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlT                   ctrl,
  input  logic [LaneW*Lanes-1:0] srcA,
  input  logic [LaneW*Lanes-1:0] srcB,
  output logic                   outValid,
  output logic [LaneW*Lanes-1:0] result,
  output logic                   illegalOp,
  output logic [Lanes-1:0]       signOut,
  output logic [Lanes-1:0]       zeroOut
);
  localparam int VecW  = LaneW * Lanes;
  localparam int Pairs = Lanes / 2;

  logic [VecW-1:0] addRes, mulLoRes, mulHiRes, nextRes;

  // Lane adders: carry from even lane into odd lane only when fused.
  generate
    for (genvar p = 0; p < Pairs; p++) begin : gPair
      logic [LaneW:0]   loSum;
      logic [LaneW-1:0] hiSum;
      logic [LaneW-1:0] aLo, bLo, aHi, bHi;
      assign aLo = srcA[(2*p)*LaneW +: LaneW];
      assign bLo = srcB[(2*p)*LaneW +: LaneW];
      assign aHi = srcA[(2*p+1)*LaneW +: LaneW];
      assign bHi = srcB[(2*p+1)*LaneW +: LaneW];
      assign loSum = {1'b0, aLo} + {1'b0, bLo};
      assign hiSum = aHi + bHi + {{(LaneW-1){1'b0}}, ctrl.fuse & loSum[LaneW]};
      assign addRes[(2*p)*LaneW +: LaneW]   = loSum[LaneW-1:0];
      assign addRes[(2*p+1)*LaneW +: LaneW] = hiSum;

      // Full-width product of the even lane.
      logic signed [LaneW:0]     mA, mB;
      logic signed [2*LaneW+1:0] prod;
      assign mA = {ctrl.signedMul & aLo[LaneW-1], aLo};
      assign mB = {ctrl.signedMul & bLo[LaneW-1], bLo};
      assign prod = mA * mB;
      assign mulHiRes[(2*p)*LaneW +: 2*LaneW] = prod[2*LaneW-1:0];
    end

    // Low-half products; low bits are sign-independent.
    for (genvar l = 0; l < Lanes; l++) begin : gLane
      logic [2*LaneW-1:0] lp;
      assign lp = srcA[l*LaneW +: LaneW] * srcB[l*LaneW +: LaneW];
      assign mulLoRes[l*LaneW +: LaneW] = lp[LaneW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (ctrl.sel)
      SEL_ADD:   nextRes = addRes;
      SEL_MULLO: nextRes = mulLoRes;
      SEL_MULHI: nextRes = mulHiRes;
      SEL_AND:   nextRes = srcA & srcB;
      SEL_OR:    nextRes = srcA | srcB;
      SEL_XOR:   nextRes = srcA ^ srcB;
      default:   nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
      result    <= '0;
      signOut   <= '0;
      zeroOut   <= '0;
    end else begin
      outValid  <= ctrl.load;
      illegalOp <= ctrl.load & ctrl.illegal;
      if (ctrl.load) begin
        result <= nextRes;
        for (int i = 0; i < Lanes; i++) begin
          signOut[i] <= nextRes[i*LaneW + LaneW-1];
          zeroOut[i] <= (nextRes[i*LaneW +: LaneW] == '0);
        end
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid) else $error("valid lost"); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> !outValid) else $error("spurious valid"); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(result)) else $error("result changed while idle"); // R8
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && result == '0)) else $error("illegal op nonzero"); // R9
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.illegal) |=> illegalOp) else $error("illegal flag missing"); // R9
endmodule

// File: rtl/vecIntAlu.sv
module vecIntAlu
  import vecIntAlu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             illegalOp,
  output logic [LANES-1:0] signOut,
  output logic [LANES-1:0] zeroOut
);
  ctrlT ctrl;

  vecIntAluCtrl uCtrl (.inValid(inValid), .opCode(opCode), .ctrl(ctrl));

  vecIntAluPath #(.LaneW(LANE_W), .Lanes(LANES)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result), .illegalOp(illegalOp),
    .signOut(signOut), .zeroOut(zeroOut)
  );

  AST_STATUS_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> signOut == {result[63], result[47], result[31], result[15]})
    else $error("sign mismatch"); // R10
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> zeroOut[0] == (result[15:0] == 16'h0))
    else $error("zero mismatch"); // R10
endmodule

// File: tb/vecIntAlu_test.sv
`timescale 1ns/1ps
module vecIntAlu_test;
  logic clk = 0, rstN = 0, inValid = 0;
  logic [7:0] opCode = 0;
  logic [63:0] srcA = 0, srcB = 0;
  logic outValid, illegalOp;
  logic [63:0] result;
  logic [3:0] signOut, zeroOut;
  int nChk = 0, nBad = 0;
  logic done = 0;

  always #5 clk = ~clk;

  vecIntAlu uut (.clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result),
    .illegalOp(illegalOp), .signOut(signOut), .zeroOut(zeroOut));

  function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a, b);
    logic [63:0] r = '0;
    case (op)
      8'h21: for (int i = 0; i < 4; i++) r[i*16 +: 16] = a[i*16 +: 16] + b[i*16 +: 16];
      8'h22: begin r[31:0] = a[31:0] + b[31:0]; r[63:32] = a[63:32] + b[63:32]; end
      8'h2C: for (int i = 0; i < 4; i++)
               r[i*16 +: 16] = 16'($signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]));
      8'h28: for (int i = 0; i < 4; i++) r[i*16 +: 16] = 16'(a[i*16 +: 16] * b[i*16 +: 16]);
      8'h2E: begin
        r[31:0]  = 32'($signed({{16{a[15]}}, a[15:0]}) * $signed({{16{b[15]}}, b[15:0]}));
        r[63:32] = 32'($signed({{16{a[47]}}, a[47:32]}) * $signed({{16{b[47]}}, b[47:32]}));
      end
      8'h2A: begin
        r[31:0]  = {16'h0, a[15:0]} * {16'h0, b[15:0]};
        r[63:32] = {16'h0, a[47:32]} * {16'h0, b[47:32]};
      end
      8'h30: r = a & b;
      8'h31: r = a | b;
      8'h32: r = a ^ b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic bit legal(input logic [7:0] op);
    return op inside {8'h21, 8'h22, 8'h28, 8'h2A, 8'h2C, 8'h2E, 8'h30, 8'h31, 8'h32};
  endfunction

  task automatic check(input string req, input logic [63:0] act, exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one op, then sample 1 cycle later mid-period and check everything.
  task automatic runOp(input string req, input logic [7:0] op, input logic [63:0] a, b);
    logic [63:0] e;
    logic [3:0] es, ez;
    e = model(op, a, b);
    for (int i = 0; i < 4; i++) begin
      es[i] = e[i*16+15];
      ez[i] = (e[i*16 +: 16] == 16'h0);
    end
    @(negedge clk);
    inValid = 1; opCode = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 0;
    check(req, result, e);
    check({req, " R8 valid"}, {63'h0, outValid}, 64'h1);
    check({req, " R9 illegal"}, {63'h0, illegalOp}, {63'h0, !legal(op)});
    check({req, " R10 sign"}, {60'h0, signOut}, {60'h0, es});
    check({req, " R10 zero"}, {60'h0, zeroOut}, {60'h0, ez});
  endtask

  task automatic testReset();
    check("R11 valid", {63'h0, outValid}, 64'h0);
    check("R11 illegal", {63'h0, illegalOp}, 64'h0);
    check("R11 result", result, 64'h0);
    check("R11 status", {56'h0, signOut, zeroOut}, 64'h0);
  endtask

  task automatic testAdds();
    runOp("R1 lane wrap", 8'h21, 64'hFFFF_7FFF_FFFF_FFFF, 64'h0001_0001_0001_0001);
    runOp("R2 carry X->Y", 8'h22, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    runOp("R2 no carry Y->Z", 8'h22, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    runOp("R2 carry Z->W", 8'h22, 64'h1234_FFFF_0000_0000, 64'h0000_0001_0000_0000);
  endtask

  task automatic testMuls();
    runOp("R3 signed lo", 8'h2C, 64'h8000_FFFF_0003_FFFF, 64'h0002_FFFF_FFFE_0002);
    runOp("R4 unsigned lo", 8'h28, 64'h8000_FFFF_0003_FFFF, 64'h0002_FFFF_FFFE_0002);
    runOp("R5 signed hi", 8'h2E, 64'h0000_8000_0000_FFFF, 64'h0000_8000_0000_0002);
    runOp("R6 unsigned hi", 8'h2A, 64'h0000_8000_0000_FFFF, 64'h0000_8000_0000_0002);
  endtask

  task automatic testLogic();
    runOp("R7 and", 8'h30, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_8001_FFFF);
    runOp("R7 or",  8'h31, 64'hF0F0_1234_0000_0000, 64'h0FF0_0000_8001_0000);
    runOp("R7 xor", 8'h32, 64'hFFFF_1234_AAAA_0000, 64'hFFFF_0000_5555_0000);
  endtask

  task automatic testIllegalAndHold();
    logic [63:0] keep;
    runOp("R9 unknown", 8'h7F, 64'h1, 64'h2);
    runOp("R8 before hold", 8'h31, 64'h00AB_0000_0000_0001, 64'h0);
    keep = result;
    @(negedge clk);
    inValid = 0; opCode = 8'h32; srcA = '1; srcB = 64'h5;
    @(negedge clk);
    check("R8 idle valid low", {63'h0, outValid}, 64'h0);
    check("R9 idle illegal low", {63'h0, illegalOp}, 64'h0);
    check("R8 idle hold", result, keep);
  endtask

  task automatic testSweep();
    logic [7:0] ops[9] = '{8'h21, 8'h22, 8'h28, 8'h2A, 8'h2C, 8'h2E, 8'h30, 8'h31, 8'h32};
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 90; k++) begin
      logic [63:0] a, b;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); a = s;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17); b = s;
      runOp("R1-sweep", ops[k % 9], a, b);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    testAdds();
    testMuls();
    testLogic();
    testIllegalAndHold();
    testSweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule